// File: doc/BRIEF.md
# Programmable High/Low-Time Clock Divider

This block derives a slower clock from a source clock, with the shape of each output period taken from one control word. The word carries two independent counts, one for the number of source cycles the output stays high and one for the number it stays low, so the division ratio is their sum and the duty cycle is set directly rather than derived. A flag stretches the high phase by half a source cycle on the falling edge, which brings odd ratios to an even duty. A second flag passes the source clock straight through.

The control word is sampled only when the current output period finishes. A change in the middle of a period therefore never cuts a pulse short. A hold flag in the word stops it from being taken at all. While reset is low the output is held low. Once reset is released the block starts out passing the source clock through.

Top module: `hl_clk_div`

## Requirements
- R1: While rst_n is low, clk_out is 0. After reset is released the block is in pass-through mode until a word is taken at the first source rising edge.
- R2: When bit 13 of the accepted word is 1, clk_out equals clk_src, whatever the two count fields hold.
- R3: When bit 13 is 0 and both count fields are 0, the word acts exactly as if bit 13 were 1.
- R4: Otherwise clk_out is high for H source cycles, then low for L source cycles, and this repeats. H is bits 11:6 and L is bits 5:0. Either of them may be 0.
- R5: When bit 12 of the accepted word is 1, each high-to-low transition of clk_out is delayed to the next falling edge of clk_src. The low-to-high transitions are not moved.
- R6: A new word is taken only on the source rising edge that ends the current output period, that is the edge after the last low cycle. In pass-through mode every rising edge ends a period.
- R7: When bit 14 of the presented word is 1 at a period boundary, the word is not taken and the current setting continues unchanged.
- R8: Bits 31:15 of the control word have no effect on clk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word: low count, high count, stretch, pass-through and hold fields |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with its default parameters: 6-bit counts in a 32-bit word, with the falling-edge stretch stage generated in. This puts the field positions at 5:0, 11:6, 12, 13 and 14, so words with reserved bits set can be presented, and it exercises the half-cycle path. A behavioural model predicts clk_out in both halves of every source cycle. The words covered include a ratio of 1 through the counts, one count zero, mid-period rewrites and held words, so every transition of the setting is compared at the boundary where it lands.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;
   // Field positions derived from the count width
   function automatic int f_hi_lsb(input int cw);
      return cw;
   endfunction
   function automatic int f_stretch_bit(input int cw);
      return 2 * cw;
   endfunction
   function automatic int f_pass_bit(input int cw);
      return 2 * cw + 1;
   endfunction
   function automatic int f_hold_bit(input int cw);
      return 2 * cw + 2;
   endfunction
endpackage

// File: rtl/hlcd_cfg.sv
module hlcd_cfg
   import hlcd_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int WORD_W = 32
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  hi,
   output logic [CNT_W-1:0]  lo,
   output logic              stretch,
   output logic              pass,
   output logic [CNT_W-1:0]  hi_nxt
);
   localparam int HI_LSB = f_hi_lsb(CNT_W);
   localparam int STR_B  = f_stretch_bit(CNT_W);
   localparam int PAS_B  = f_pass_bit(CNT_W);
   localparam int HLD_B  = f_hold_bit(CNT_W);

   logic [CNT_W-1:0] w_hi, w_lo;
   logic             w_pass, take;

   assign w_lo   = word[CNT_W-1:0];
   assign w_hi   = word[HI_LSB +: CNT_W];
   assign w_pass = word[PAS_B] | ((w_hi == '0) & (w_lo == '0));
   assign take   = boundary & ~word[HLD_B];
   assign hi_nxt = take ? w_hi : hi;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         hi      <= '0;
         lo      <= '0;
         stretch <= 1'b0;
         pass    <= 1'b1;
      end else if (take) begin
         hi      <= w_hi;
         lo      <= w_lo;
         stretch <= word[STR_B];
         pass    <= w_pass;
      end
   end

   // R6: setting only moves at a period boundary
   a_r6_cfg_hold: assert property (@(posedge clk_src) disable iff (!rst_n)
      !boundary |=> $stable({hi, lo, stretch, pass}));
   // R3: a divide setting never has zero total
   a_r3_no_zero_ratio: assert property (@(posedge clk_src) disable iff (!rst_n)
      !pass |-> ((hi != '0) || (lo != '0)));
endmodule

// File: rtl/hlcd_count.sv
module hlcd_count #(
   parameter int CNT_W = 6
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic             pass,
   input  logic [CNT_W-1:0] hi,
   input  logic [CNT_W-1:0] lo,
   input  logic [CNT_W-1:0] hi_nxt,
   output logic             boundary,
   output logic             q
);
   localparam int POS_W = CNT_W + 1;

   logic [POS_W-1:0] pos, pos_inc, total;

   assign total    = POS_W'(hi) + POS_W'(lo);
   assign pos_inc  = pos + POS_W'(1);
   assign boundary = pass | (pos_inc == total);

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
         q   <= 1'b0;
      end else if (boundary) begin
         pos <= '0;
         q   <= (hi_nxt != '0);
      end else begin
         pos <= pos_inc;
         q   <= (pos_inc < POS_W'(hi));
      end
   end

   // R4: position stays inside the period
   a_r4_pos_in_period: assert property (@(posedge clk_src) disable iff (!rst_n)
      !pass |-> (pos < total));
   // R4: high phase starts only at period start
   a_r4_rise_at_start: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(q) |-> (pos == '0));
   // R4: high phase ends after hi cycles or at a new period
   a_r4_fall_at_hi: assert property (@(posedge clk_src) disable iff (!rst_n)
      $fell(q) |-> ((pos == POS_W'(hi)) || (pos == '0)));
endmodule

// File: rtl/hlcd_outmux.sv
module hlcd_outmux #(
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic q,
   input  logic stretch,
   input  logic pass,
   output logic clk_out
);
   logic q_late;

   generate
      if (STRETCH_EN) begin : g_stretch
         always_ff @(negedge clk_src or negedge rst_n) begin
            if (!rst_n) q_late <= 1'b0;
            else        q_late <= q;
         end
      end else begin : g_plain
         assign q_late = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!rst_n)       clk_out = 1'b0;
      else if (pass)    clk_out = clk_src;
      else if (stretch) clk_out = q | q_late;
      else              clk_out = q;
   end

   // R1: output low throughout reset
   always_comb begin
      if (!rst_n) a_r1_low_in_reset: assert (!clk_out);
   end
endmodule

// File: rtl/hl_clk_div.sv
module hl_clk_div #(
   parameter int CNT_W      = 6,
   parameter int WORD_W     = 32,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic              clk_src,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] ctrl_word,
   output logic              clk_out
);
   localparam int MIN_WORD = 2 * CNT_W + 3;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (WORD_W < MIN_WORD) begin : g_bad_word
         $error("WORD_W too small for the fields");
      end
   endgenerate

   logic [CNT_W-1:0] hi, lo, hi_nxt;
   logic             stretch, pass, boundary, q;

   hlcd_cfg #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cfg (
      .clk_src(clk_src), .rst_n(rst_n), .boundary(boundary), .word(ctrl_word),
      .hi(hi), .lo(lo), .stretch(stretch), .pass(pass), .hi_nxt(hi_nxt));

   hlcd_count #(.CNT_W(CNT_W)) u_count (
      .clk_src(clk_src), .rst_n(rst_n), .pass(pass), .hi(hi), .lo(lo),
      .hi_nxt(hi_nxt), .boundary(boundary), .q(q));

   hlcd_outmux #(.STRETCH_EN(STRETCH_EN)) u_outmux (
      .clk_src(clk_src), .rst_n(rst_n), .q(q), .stretch(stretch),
      .pass(pass), .clk_out(clk_out));
endmodule

// File: tb/hl_clk_div_bench.sv
module hl_clk_div_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] word = 32'h0;
   logic        clk_out;

   int    n_chk = 0, n_fail = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // model state
   int m_pass = 1, m_hi = 0, m_lo = 0, m_str = 0, m_pos = 0, m_q = 0, m_qold = 0;

   always #4 clk = ~clk;

   hl_clk_div u_hl_clk_div (.clk_src(clk), .rst_n(rst_n), .ctrl_word(word), .clk_out(clk_out));

   function automatic int w_hi(input logic [31:0] w);
      return int'(w[11:6]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pass = 1; m_hi = 0; m_lo = 0; m_str = 0; m_pos = 0; m_q = 0; m_qold = 0;
      end else begin
         m_qold = m_q;
         if (m_pass != 0 || m_pos + 1 == m_hi + m_lo) begin
            if (!word[14]) begin
               m_hi   = w_hi(word);
               m_lo   = int'(word[5:0]);
               m_str  = int'(word[12]);
               m_pass = (word[13] || (m_hi == 0 && m_lo == 0)) ? 1 : 0;
            end
            m_pos = 0;
            m_q   = (m_hi != 0) ? 1 : 0;
         end else begin
            m_pos = m_pos + 1;
            m_q   = (m_pos < m_hi) ? 1 : 0;
         end
      end
   end

   task automatic check(input logic exp, input string ph);
      n_chk++;
      if (clk_out !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) at %0t: clk_out=%b expected=%b", tag, ph, $time, clk_out, exp);
      end
   endtask

   always @(posedge clk) begin
      logic e;
      #2;
      if (!rst_n) e = 1'b0;
      else if (m_pass != 0) e = 1'b1;
      else if (m_str != 0) e = (m_q != 0) || (m_qold != 0);
      else e = (m_q != 0);
      if (!done) check(e, "high half");
      #4;
      if (!rst_n) e = 1'b0;
      else if (m_pass != 0) e = 1'b0;
      else e = (m_q != 0);
      if (!done) check(e, "low half");
   end

   task automatic set_word(input string t, input logic [31:0] w, input int cycles);
      @(posedge clk); #7;
      tag  = t;
      word = w;
      repeat (cycles) @(posedge clk);
   endtask

   function automatic logic [31:0] mk(input int hi, input int lo, input bit str,
                                      input bit pas, input bit hold);
      return {17'h0, hold, pas, str, 6'(hi), 6'(lo)};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #7 rst_n = 1'b1;                                     // R1 reset then pass-through
      set_word("R1", mk(0, 0, 0, 1, 0), 4);
      set_word("R4", mk(2, 3, 0, 0, 0), 30);               // R4 ratio 5
      set_word("R4", mk(3, 3, 0, 0, 0), 30);               // R4 even
      set_word("R6", mk(1, 1, 0, 0, 0), 2);                // R6 mid-period rewrite
      set_word("R6", mk(4, 2, 0, 0, 0), 25);
      set_word("R5", mk(2, 3, 1, 0, 0), 30);               // R5 stretch odd ratio
      set_word("R5", mk(1, 0, 1, 0, 0), 10);               // R5 stretch, constant high
      set_word("R4", mk(0, 4, 0, 0, 0), 12);               // R4 zero high
      set_word("R7", mk(1, 2, 0, 0, 1), 20);               // R7 held word ignored
      set_word("R8", {17'h1ABCD, mk(1, 2, 0, 0, 0)}[31:0] | 32'hFFFF_8000 & 32'hFFFF_8000 | mk(1, 2, 0, 0, 0), 24); // R8 reserved bits
      set_word("R2", mk(5, 7, 1, 1, 0), 10);               // R2 pass-through with counts
      set_word("R3", mk(0, 0, 1, 0, 0), 10);               // R3 zero counts act as pass-through
      set_word("R4", mk(1, 0, 0, 0, 0), 4);                // R4 ratio 1 through counts
      set_word("R1", mk(3, 2, 0, 0, 0), 6);
      @(posedge clk); #7 rst_n = 1'b0; tag = "R1";        // R1 reset mid-run
      repeat (3) @(posedge clk);
      #1 done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule